// File: doc/BRIEF.md
# Asynchronous Serial Byte Receiver

This block turns a raw asynchronous serial line into bytes in the receiver's clock domain. Each frame has one low start bit, eight data bits sent least significant first, and one high stop bit. There is no parity. The line is idle high. The pin passes through a chain of synchronizing flops before any other logic sees it, so only one clocked element ever samples the unsynchronized signal. A further flop after the chain, together with an AND gate, turns a high-to-low step of the synchronized line into a one-cycle start pulse.

When the start pulse arrives, the bit-period counter and the bit-index counter are loaded on the same clock edge. The period counter first runs for half a bit, so that every later sample lands in the middle of a bit. A start bit that has gone high again by its centre is treated as noise. At the centre of the last data bit, the assembled byte moves into an output register and a one-cycle valid strobe is raised. The stop bit is sampled one bit period later and reported as a framing fault if it is low. The bit period in clock cycles is a parameter.

Top module: `uart_rx_core`

## Requirements
- R1: While reset is asserted, and on the first cycles after it, `data_valid` and `framing_error` are 0 and `data_byte` is 0x00.
- R2: A frame whose data bits d0..d7 are sent least significant first yields `data_byte` = {d7,...,d0}.
- R3: `data_valid` is high for exactly one cycle per frame. With two synchronizer stages, it is first seen after clock edge number 3 + CLKS_PER_BIT/2 + 8*CLKS_PER_BIT, counting from the first rising edge after the line falls.
- R4: A low pulse that has ended before the middle of the start bit produces neither `data_valid` nor `framing_error`, and the receiver then accepts the next frame normally.
- R5: A stop bit sampled as 0 gives a one-cycle `framing_error` pulse exactly CLKS_PER_BIT cycles after the `data_valid` pulse of that frame. A stop bit of 1 gives no pulse. `framing_error` and `data_valid` are never high in the same cycle.
- R6: Falling edges inside a frame, whether in data bits or in the stop bit, do not restart reception: each frame gives exactly one `data_valid`.
- R7: Frames sent back to back, with a start bit directly after the previous stop bit, are all received correctly.
- R8: `data_byte` changes only in a cycle where `data_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_pin | input | 1 | Raw asynchronous serial line, idle high |
| data_byte | output | 8 | Last received byte, held until the next one |
| data_valid | output | 1 | One-cycle strobe when `data_byte` updates |
| framing_error | output | 1 | One-cycle strobe when a stop bit reads low |

## Verification
The bench builds the receiver with eight clock cycles per bit, so a frame lasts only 80 cycles. This makes it cheap to send all 256 byte values back to back and to check the exact cycle of every strobe against the formula in R3. The short bit also lets a two-cycle glitch and a low stop bit be placed at chosen points of a frame. Recovery after each of these is then observed on the next frame.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_raw,
  output logic line_sync,
  output logic line_fall
);
  logic [SYNC_STAGES-1:0] chain_q;
  logic                   older_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b1;
        else if (g == 0) chain_q[g] <= line_raw;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) older_q <= 1'b1;
    else        older_q <= chain_q[SYNC_STAGES-1];
  end

  assign line_sync = chain_q[SYNC_STAGES-1];
  assign line_fall = older_q & ~chain_q[SYNC_STAGES-1];
endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_half,
  input  logic load_full,
  output logic tick
);
  localparam int CNT_W = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(CLKS_PER_BIT/2 - 1);
  localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(CLKS_PER_BIT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_half)          cnt_d = HALF_M1;
    else if (load_full)     cnt_d = FULL_M1;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = (cnt_q == '0);
endmodule

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_sync,
  input  logic                 line_fall,
  input  logic                 tick,
  output logic                 load_half,
  output logic                 load_full,
  output logic [DATA_BITS-1:0] byte_out,
  output logic                 byte_valid,
  output logic                 stop_bad
);
  localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_BITS - 1);

  rx_state_e            state_q, state_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [DATA_BITS-1:0] shift_q, shift_d;
  logic [DATA_BITS-1:0] hold_q, hold_d;
  logic                 valid_q, valid_d;
  logic                 bad_q, bad_d;
  logic [DATA_BITS-1:0] shifted;

  assign shifted = {line_sync, shift_q[DATA_BITS-1:1]};

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    shift_d   = shift_q;
    hold_d    = hold_q;
    valid_d   = 1'b0;
    bad_d     = 1'b0;
    load_half = 1'b0;
    load_full = 1'b0;
    unique case (state_q)
      RX_IDLE: begin
        if (line_fall) begin
          load_half = 1'b1;
          idx_d     = '0;
          state_d   = RX_START;
        end
      end
      RX_START: begin
        if (tick) begin
          if (line_sync) begin
            state_d = RX_IDLE;
          end else begin
            load_full = 1'b1;
            state_d   = RX_DATA;
          end
        end
      end
      RX_DATA: begin
        if (tick) begin
          load_full = 1'b1;
          shift_d   = shifted;
          idx_d     = idx_q + 1'b1;
          if (idx_q == LAST_IDX) begin
            hold_d  = shifted;
            valid_d = 1'b1;
            state_d = RX_STOP;
          end
        end
      end
      RX_STOP: begin
        if (tick) begin
          bad_d   = ~line_sync;
          state_d = RX_IDLE;
        end
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      idx_q   <= '0;
      shift_q <= '0;
      hold_q  <= '0;
      valid_q <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      shift_q <= shift_d;
      hold_q  <= hold_d;
      valid_q <= valid_d;
      bad_q   <= bad_d;
    end
  end

  assign byte_out   = hold_q;
  assign byte_valid = valid_q;
  assign stop_bad   = bad_q;
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core #(
  parameter int CLKS_PER_BIT = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_pin,
  output logic [7:0] data_byte,
  output logic       data_valid,
  output logic       framing_error
);
  localparam int DATA_BITS = 8;

  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  logic       line_sync, line_fall, tick, load_half, load_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  rx_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .line_raw  (rx_pin),
    .line_sync (line_sync),
    .line_fall (line_fall)
  );

  rx_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load_half (load_half),
    .load_full (load_full),
    .tick      (tick)
  );

  rx_frame_ctrl #(.DATA_BITS(DATA_BITS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .line_sync  (line_sync),
    .line_fall  (line_fall),
    .tick       (tick),
    .load_half  (load_half),
    .load_full  (load_full),
    .byte_out   (data_byte),
    .byte_valid (data_valid),
    .stop_bad   (framing_error)
  );
endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk #(
  parameter int CLKS_PER_BIT = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] data_byte,
  input logic       data_valid,
  input logic       framing_error
);
  localparam int GAP_W = $clog2(CLKS_PER_BIT + 2) + 1;
  localparam logic [GAP_W-1:0] GAP_MAX = {GAP_W{1'b1}};

  logic [GAP_W-1:0] since_valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     since_valid_q <= GAP_MAX;
    else if (data_valid)            since_valid_q <= GAP_W'(1);
    else if (since_valid_q != GAP_MAX) since_valid_q <= since_valid_q + 1'b1;
  end

  // R3
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |=> !data_valid);

  // R5
  ferr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    framing_error |=> !framing_error);

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_valid && framing_error));

  // R5
  ferr_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    framing_error |-> (since_valid_q == GAP_W'(CLKS_PER_BIT)));

  // R8
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_valid |-> $stable(data_byte));
endmodule

bind uart_rx_core uart_rx_core_chk #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .data_byte     (data_byte),
  .data_valid    (data_valid),
  .framing_error (framing_error)
);

// File: tb/uart_rx_core_tb.sv
module uart_rx_core_tb;
  localparam int CPB     = 8;
  localparam int HALF    = CPB / 2;
  localparam int LAT_V   = 3 + HALF + 8 * CPB;
  localparam int LAT_F   = 3 + HALF + 9 * CPB;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_pin;
  logic [7:0] data_byte;
  logic       data_valid;
  logic       framing_error;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int vcount = 0, fcount = 0;
  int last_v_cyc = 0, last_f_cyc = 0;
  logic [7:0] last_byte = 8'h00;
  logic [7:0] prev_byte = 8'h00;
  int hold_viol = 0;
  int start_cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_rx_core #(.CLKS_PER_BIT(CPB), .SYNC_STAGES(2)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_pin        (rx_pin),
    .data_byte     (data_byte),
    .data_valid    (data_valid),
    .framing_error (framing_error)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (data_valid) begin
      vcount++;
      last_v_cyc = cyc;
      last_byte  = data_byte;
    end else if (rst_n && data_byte != prev_byte) begin
      hold_viol++;
    end
    if (framing_error) begin
      fcount++;
      last_f_cyc = cyc;
    end
    prev_byte = data_byte;
  end

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop_bit);
    @(negedge clk);
    rx_pin = 1'b0;
    start_cyc = cyc;
    idle(CPB - 1);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      rx_pin = b[k];
      idle(CPB - 1);
    end
    @(negedge clk);
    rx_pin = stop_bit;
    idle(CPB - 1);
    #1;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v0, f0;
    rst_n  = 1'b0;
    rx_pin = 1'b1;
    idle(4);
    // R1 during reset
    check("R1 valid", int'(data_valid), 0);
    check("R1 ferr", int'(framing_error), 0);
    check("R1 byte", int'(data_byte), 0);
    rst_n = 1'b1;
    idle(1);
    check("R1 after release", int'({data_valid, framing_error, data_byte}), 0);
    idle(6);

    // R2 R3 R6 R7: all byte values, back to back
    for (int b = 0; b < 256; b++) begin
      v0 = vcount;
      f0 = fcount;
      send_frame(8'(b), 1'b1);
      check("R6 one valid per frame", vcount - v0, 1);
      check("R2 R7 byte", int'(last_byte), b);
      check("R3 valid cycle", last_v_cyc - start_cyc, LAT_V);
      check("R5 no ferr on good stop", fcount - f0, 0);
    end

    // R4 glitch shorter than half a bit
    idle(3);
    v0 = vcount;
    f0 = fcount;
    @(negedge clk);
    rx_pin = 1'b0;
    idle(2);
    rx_pin = 1'b1;
    idle(12 * CPB);
    check("R4 no valid on glitch", vcount - v0, 0);
    check("R4 no ferr on glitch", fcount - f0, 0);
    v0 = vcount;
    send_frame(8'h3C, 1'b1);
    check("R4 recovery count", vcount - v0, 1);
    check("R4 recovery byte", int'(last_byte), 8'h3C);

    // R5 low stop bit
    v0 = vcount;
    f0 = fcount;
    send_frame(8'hA5, 1'b0);
    check("R5 byte still delivered", int'(last_byte), 8'hA5);
    check("R5 ferr count", fcount - f0, 1);
    check("R5 ferr cycle", last_f_cyc - start_cyc, LAT_F);
    check("R5 ferr after valid", last_f_cyc - last_v_cyc, CPB);
    @(negedge clk);
    rx_pin = 1'b1;
    idle(2);
    v0 = vcount;
    f0 = fcount;
    send_frame(8'h81, 1'b1);
    check("R6 recovery after bad stop", vcount - v0, 1);
    check("R6 recovery byte", int'(last_byte), 8'h81);
    check("R5 no ferr after recovery", fcount - f0, 0);

    idle(3 * CPB);
    // R8
    check("R8 byte held", hold_viol, 0);
    check("R8 byte stable idle", int'(data_byte), 8'h81);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule